// File: doc/BRIEF.md
# Interrupt Redirection Table with Indirect Register Access

This block holds one 64-bit routing entry for each interrupt pin and records which pins have a request waiting. Software never addresses the entries directly. It first writes an index into a select register, then reads or writes a 32-bit data window. The select value picks an identification register, a version register, a register that always reads zero, or one half of one routing entry. The number of pins is a parameter. The version register reports that number to software as the highest entry index.

Each pin latches a pending request in one of two ways. In edge mode the request is set on a rising input and held until it is acknowledged. In level mode the request follows the input. Input line 0 is steered onto pin 2, so pin 0 never requests. Of all pending pins whose entry is not masked, the lowest-numbered one is presented on a service output together with the vector byte of its entry. A downstream agent accepts it with an acknowledge. Reset masks every entry.

Top module: `irq_route_table`

## Requirements
- R1: After reset the ID is 0, the select register is 0, no pin is pending, svc_valid is low, and every entry reads 0x0000_0000_0001_0000 (bit 16 set, so the entry is masked).
- R2: A write at byte offset 0x00 stores wdata[7:0] as the select value. A read at offset 0x00 returns the select value zero-extended. A read at any offset other than 0x00 and 0x10 returns zero. Read data appears on rdata in the cycle after rd_en and holds until the next read.
- R3: Through the window at offset 0x10, select 0x00 is the ID. A write stores wdata[31:24]. A read returns the ID in bits 31:24 and zero in all other bits.
- R4: Select 0x01 reads 0x11 in bits 7:0 and (NPINS−1) in bits 23:16, with all other bits zero. Select 0x02 and selects 0x03 to 0x0F read zero. Writes to these selects change nothing.
- R5: A select s ≥ 0x10 addresses entry (s−0x10)>>1. An odd s addresses bits 63:32 and an even s addresses bits 31:0. A write replaces only the addressed half.
- R6: When the entry number is NPINS or more, a window write is ignored and a window read returns zero.
- R7: When entry bit 15 is 0 (edge mode), the pin's pending bit is set by a rising edge of its input. It stays set after the input falls, until svc_ack is high while that pin is the one shown on svc_pin.
- R8: When entry bit 15 is 1 (level mode), the pending bit equals the input level, and svc_ack does not clear it.
- R9: Pin 2 is driven by the OR of line 0 and line 2. Pin 0 never becomes pending, even when its entry is unmasked.
- R10: svc_valid is high exactly when some pending pin has entry bit 16 clear. svc_pin is then the lowest such pin and svc_vector is bits 7:0 of its entry. A masked pin stays pending and is presented once it is unmasked.
- R11: A change on an input line or a table write shows on the service outputs after exactly one rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 8 | Byte offset: 0x00 select, 0x10 window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_line | input | NPINS | Interrupt input lines |
| svc_ack | input | 1 | Accepts the presented pin |
| svc_valid | output | 1 | An unmasked pin is pending |
| svc_pin | output | $clog2(NPINS) | Lowest pending unmasked pin |
| svc_vector | output | 8 | Bits 7:0 of that pin's entry |

## Verification
Read data is registered, so the bench raises rd_en on a falling edge and samples rdata on the next falling edge, after one rising edge. Pending bits are also registered, so line changes, acknowledges and table writes reach svc_valid, svc_pin and svc_vector after one rising edge. The bench drives every stimulus on a falling edge and compares the service outputs at the following falling edge, which is exactly one rising edge later. Register reads after random writes are compared against a bench model of the ID and the table.

// File: rtl/irt_pkg.sv
package irt_pkg;

    localparam logic [7:0] OFF_SELECT = 8'h00;
    localparam logic [7:0] OFF_WINDOW = 8'h10;
    localparam logic [7:0] SEL_TABLE  = 8'h10;
    localparam logic [7:0] VER_CODE   = 8'h11;
    localparam int         BIT_MASK   = 16;
    localparam int         BIT_LEVEL  = 15;

    typedef enum logic [2:0] {
        WK_ID,
        WK_VERSION,
        WK_ZERO,
        WK_ENT_LO,
        WK_ENT_HI
    } win_kind_e;

    typedef struct packed {
        win_kind_e  kind;
        logic [7:0] entry;
    } win_dec_t;

    function automatic win_dec_t win_decode(input logic [7:0] sel);
        win_dec_t r;
        logic [7:0] off;
        r.entry = 8'h00;
        off     = sel - SEL_TABLE;
        if (sel == 8'h00) begin
            r.kind = WK_ID;
        end else if (sel == 8'h01) begin
            r.kind = WK_VERSION;
        end else if (sel < SEL_TABLE) begin
            r.kind = WK_ZERO;
        end else begin
            r.entry = {1'b0, off[7:1]};
            r.kind  = off[0] ? WK_ENT_HI : WK_ENT_LO;
        end
        return r;
    endfunction

endpackage

// File: rtl/irt_pending.sv
module irt_pending #(
    parameter int NPINS = 24,
    parameter int PIN_W = $clog2(NPINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] line_in,
    input  logic [NPINS-1:0] lvl_mode,
    input  logic             ack,
    input  logic [PIN_W-1:0] ack_pin,
    output logic [NPINS-1:0] pend
);

    typedef struct packed {
        logic [NPINS-1:0] prev;
        logic [NPINS-1:0] pend;
    } pst_t;

    pst_t s_d, s_q;
    logic [NPINS-1:0] src;

    // Line 0 is steered to pin 2; pin 0 has no source.
    for (genvar g = 0; g < NPINS; g++) begin : g_src
        if (g == 0) begin : g_zero
            assign src[g] = 1'b0;
        end else if (g == 2) begin : g_merge
            assign src[g] = line_in[2] | line_in[0];
        end else begin : g_plain
            assign src[g] = line_in[g];
        end
    end

    always_comb begin
        s_d      = s_q;
        s_d.prev = src;
        for (int p = 0; p < NPINS; p++) begin
            if (lvl_mode[p]) begin
                s_d.pend[p] = src[p];
            end else begin
                if (ack && ack_pin == PIN_W'(p)) begin
                    s_d.pend[p] = 1'b0;
                end
                if (src[p] && !s_q.prev[p]) begin
                    s_d.pend[p] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pend = s_q.pend;

endmodule

// File: rtl/irt_lowest.sv
module irt_lowest #(
    parameter int NPINS = 24,
    parameter int PIN_W = $clog2(NPINS)
) (
    input  logic [NPINS-1:0] req,
    output logic             found,
    output logic [PIN_W-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NPINS - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = PIN_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
    import irt_pkg::*;
#(
    parameter int NPINS = 24,
    parameter int PIN_W = $clog2(NPINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [7:0]       addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    input  logic [NPINS-1:0] irq_line,
    input  logic             svc_ack,
    output logic             svc_valid,
    output logic [PIN_W-1:0] svc_pin,
    output logic [7:0]       svc_vector
);

    localparam logic [63:0] ENTRY_RST = 64'h1 << BIT_MASK;
    localparam logic [7:0]  MAX_ENTRY = 8'(NPINS - 1);

    typedef struct packed {
        logic [7:0]                  sel;
        logic [7:0]                  id;
        logic [31:0]                 rdata;
        logic [NPINS-1:0][63:0]      tbl;
    } rst_t;

    rst_t s_d, s_q;

    win_dec_t         dec;
    logic             in_range;
    logic [PIN_W-1:0] ent_idx;
    logic [31:0]      win_val;
    logic [NPINS-1:0] mask_vec;
    logic [NPINS-1:0] lvl_vec;
    logic [7:0]       vec_arr [NPINS];
    logic [NPINS-1:0] pend_vec;
    logic [7:0]       sel_cur;

    for (genvar g = 0; g < NPINS; g++) begin : g_fields
        assign mask_vec[g] = s_q.tbl[g][BIT_MASK];
        assign lvl_vec[g]  = s_q.tbl[g][BIT_LEVEL];
        assign vec_arr[g]  = s_q.tbl[g][7:0];
    end

    assign dec      = win_decode(s_q.sel);
    assign in_range = dec.entry <= MAX_ENTRY;
    assign ent_idx  = PIN_W'(dec.entry);
    assign sel_cur  = s_q.sel;

    always_comb begin
        win_val = 32'h0;
        case (dec.kind)
            WK_ID:      win_val = {s_q.id, 24'h0};
            WK_VERSION: win_val = {8'h00, MAX_ENTRY, 8'h00, VER_CODE};
            WK_ENT_LO:  if (in_range) win_val = s_q.tbl[ent_idx][31:0];
            WK_ENT_HI:  if (in_range) win_val = s_q.tbl[ent_idx][63:32];
            default:    win_val = 32'h0;
        endcase
    end

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            if (addr == OFF_SELECT) begin
                s_d.sel = wdata[7:0];
            end else if (addr == OFF_WINDOW) begin
                case (dec.kind)
                    WK_ID:     s_d.id = wdata[31:24];
                    WK_ENT_LO: if (in_range) s_d.tbl[ent_idx][31:0]  = wdata;
                    WK_ENT_HI: if (in_range) s_d.tbl[ent_idx][63:32] = wdata;
                    default:   ;
                endcase
            end
        end
        if (rd_en) begin
            if (addr == OFF_SELECT) begin
                s_d.rdata = {24'h0, s_q.sel};
            end else if (addr == OFF_WINDOW) begin
                s_d.rdata = win_val;
            end else begin
                s_d.rdata = 32'h0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.sel   <= '0;
            s_q.id    <= '0;
            s_q.rdata <= '0;
            for (int i = 0; i < NPINS; i++) begin
                s_q.tbl[i] <= ENTRY_RST;
            end
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata = s_q.rdata;

    irt_pending #(.NPINS(NPINS), .PIN_W(PIN_W)) pend_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (irq_line),
        .lvl_mode (lvl_vec),
        .ack      (svc_ack & svc_valid),
        .ack_pin  (svc_pin),
        .pend     (pend_vec)
    );

    irt_lowest #(.NPINS(NPINS), .PIN_W(PIN_W)) pick_i (
        .req   (pend_vec & ~mask_vec),
        .found (svc_valid),
        .idx   (svc_pin)
    );

    assign svc_vector = vec_arr[svc_pin];

endmodule

// File: rtl/irt_checker.sv
module irt_checker #(
    parameter int NPINS = 24,
    parameter int PIN_W = $clog2(NPINS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [7:0]       addr,
    input logic [NPINS-1:0] pend,
    input logic [NPINS-1:0] mask_vec,
    input logic             svc_valid,
    input logic [PIN_W-1:0] svc_pin,
    input logic [7:0]       sel_q
);

    logic [NPINS-1:0] live;
    logic [NPINS-1:0] below;
    assign live  = pend & ~mask_vec;
    assign below = (NPINS'(1) << svc_pin) - NPINS'(1);

    AST_SVC_IS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        svc_valid |-> (pend[svc_pin] && !mask_vec[svc_pin])); // R10
    AST_SVC_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        svc_valid |-> ((live & below) == '0)); // R10
    AST_IDLE_NO_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !svc_valid |-> (live == '0)); // R10
    AST_PIN0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !pend[0]); // R9
    AST_SEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == 8'h00) |=> $stable(sel_q)); // R2

endmodule

bind irq_route_table irt_checker #(.NPINS(NPINS), .PIN_W(PIN_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .pend      (pend_vec),
    .mask_vec  (mask_vec),
    .svc_valid (svc_valid),
    .svc_pin   (svc_pin),
    .sel_q     (sel_cur)
);

// File: tb/irq_route_table_tb_top.sv
module irq_route_table_tb_top;

    localparam int NPINS = 24;
    localparam int PIN_W = $clog2(NPINS);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic             rd_en = 1'b0;
    logic [7:0]       addr = 8'h0;
    logic [31:0]      wdata = 32'h0;
    logic [31:0]      rdata;
    logic [NPINS-1:0] irq_line = '0;
    logic             svc_ack = 1'b0;
    logic             svc_valid;
    logic [PIN_W-1:0] svc_pin;
    logic [7:0]       svc_vector;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [63:0] tbl_m [NPINS];
    logic [7:0]  id_m;

    always #2.5 clk = ~clk;

    irq_route_table #(.NPINS(NPINS)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_line(irq_line), .svc_ack(svc_ack),
        .svc_valid(svc_valid), .svc_pin(svc_pin), .svc_vector(svc_vector)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        id_m = 8'h0;
        for (int i = 0; i < NPINS; i++) tbl_m[i] = 64'h1_0000;
    endtask

    function automatic logic [31:0] exp_win(input logic [7:0] s);
        int e;
        if (s == 8'h00) return {id_m, 24'h0};
        if (s == 8'h01) return {8'h0, 8'(NPINS - 1), 8'h0, 8'h11};
        if (s < 8'h10) return 32'h0;
        e = (int'(s) - 16) >> 1;
        if (e >= NPINS) return 32'h0;
        return s[0] ? tbl_m[e][63:32] : tbl_m[e][31:0];
    endfunction

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic reg_wr(input logic [7:0] s, input logic [31:0] d);
        int e;
        bus_wr(8'h00, {24'h0, s});
        bus_wr(8'h10, d);
        if (s == 8'h00) id_m = d[31:24];
        else if (s >= 8'h10) begin
            e = (int'(s) - 16) >> 1;
            if (e < NPINS) begin
                if (s[0]) tbl_m[e][63:32] = d;
                else tbl_m[e][31:0] = d;
            end
        end
    endtask

    task automatic reg_rd(input logic [7:0] s, output logic [31:0] d);
        bus_wr(8'h00, {24'h0, s});
        bus_rd(8'h10, d);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic chk_svc(input string req, input logic v, input int pin, input logic [7:0] vec);
        chk({req, " svc_valid"}, 32'(svc_valid), 32'(v));
        if (v) begin
            chk({req, " svc_pin"}, 32'(svc_pin), 32'(pin));
            chk({req, " svc_vector"}, 32'(svc_vector), 32'(vec));
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected<100000", cycles);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd4242));
        model_reset();
        do_reset();

        // R1 reset state
        chk("R1 svc idle", 32'(svc_valid), 32'h0);
        bus_rd(8'h00, rd); chk("R1 select zero", rd, 32'h0);
        reg_rd(8'h00, rd); chk("R1 id zero", rd, 32'h0);
        reg_rd(8'h10, rd); chk("R1 entry0 lo masked", rd, 32'h0001_0000);
        reg_rd(8'h11, rd); chk("R1 entry0 hi", rd, 32'h0);
        reg_rd(8'h10 + 8'(2 * (NPINS - 1)), rd); chk("R1 last entry masked", rd, 32'h0001_0000);

        // R2 select register and other offsets
        bus_wr(8'h00, 32'hABCD_EF5A);
        bus_rd(8'h00, rd); chk("R2 select readback", rd, 32'h0000_005A);
        bus_rd(8'h08, rd); chk("R2 unused offset", rd, 32'h0);
        bus_rd(8'h14, rd); chk("R2 unused offset 14", rd, 32'h0);

        // R3 ID
        reg_wr(8'h00, 32'hC3FF_FFFF);
        reg_rd(8'h00, rd); chk("R3 id", rd, 32'hC300_0000);

        // R4 version and zero registers, writes ignored
        reg_wr(8'h01, 32'hFFFF_FFFF);
        reg_rd(8'h01, rd); chk("R4 version", rd, {8'h0, 8'(NPINS - 1), 8'h0, 8'h11});
        reg_wr(8'h02, 32'hFFFF_FFFF);
        reg_rd(8'h02, rd); chk("R4 zero reg", rd, 32'h0);
        reg_rd(8'h0F, rd); chk("R4 gap reg", rd, 32'h0);

        // R5 halves
        reg_wr(8'h16, 32'h1111_2222);
        reg_wr(8'h17, 32'h3333_4444);
        reg_wr(8'h16, 32'h5555_6666);
        reg_rd(8'h16, rd); chk("R5 lo replaced", rd, 32'h5555_6666);
        reg_rd(8'h17, rd); chk("R5 hi kept", rd, 32'h3333_4444);

        // R6 out of range
        reg_wr(8'h10 + 8'(2 * NPINS), 32'hDEAD_BEEF);
        reg_rd(8'h10 + 8'(2 * NPINS), rd); chk("R6 oor read", rd, 32'h0);
        reg_rd(8'h10 + 8'(2 * NPINS) - 8'h2, rd); chk("R6 last entry untouched", rd, 32'h0001_0000);
        reg_rd(8'hFF, rd); chk("R6 top select", rd, 32'h0);

        // random register traffic against the model
        for (int k = 0; k < 60; k++) begin
            logic [7:0] s;
            s = 8'($urandom_range(0, 16 + 2 * NPINS + 6));
            reg_wr(s, $urandom());
            s = 8'($urandom_range(0, 16 + 2 * NPINS + 6));
            reg_rd(s, rd);
            chk((s >= 8'h10) ? "R5 R6 random entry" : "R3 R4 random reg", rd, exp_win(s));
        end

        do_reset();
        reg_rd(8'h1A, rd); chk("R1 masked after second reset", rd, 32'h0001_0000);

        // R7 edge pin 5, vector 0x35
        reg_wr(8'h10 + 8'd10, 32'h0000_0035);
        @(negedge clk); irq_line[5] = 1'b1;
        @(negedge clk); chk_svc("R7 R11 edge set", 1'b1, 5, 8'h35);
        irq_line[5] = 1'b0;
        @(negedge clk); chk_svc("R7 edge held", 1'b1, 5, 8'h35);

        // R8 level pin 3, vector 0x23
        reg_wr(8'h10 + 8'd6, 32'h0000_8023);
        irq_line[3] = 1'b1;
        @(negedge clk); chk_svc("R8 R10 level lowest", 1'b1, 3, 8'h23);
        svc_ack = 1'b1;
        @(negedge clk); svc_ack = 1'b0;
        chk_svc("R8 ack ignored", 1'b1, 3, 8'h23);
        irq_line[3] = 1'b0;
        @(negedge clk); chk_svc("R8 level drops", 1'b1, 5, 8'h35);
        svc_ack = 1'b1;
        @(negedge clk); svc_ack = 1'b0;
        chk_svc("R7 ack clears", 1'b0, 0, 8'h0);

        // R9 line 0 drives pin 2; pin 0 unmasked but silent
        reg_wr(8'h10, 32'h0000_0011);
        reg_wr(8'h14, 32'h0000_0042);
        irq_line[0] = 1'b1;
        @(negedge clk); chk_svc("R9 line0 to pin2", 1'b1, 2, 8'h42);
        irq_line[0] = 1'b0;
        svc_ack = 1'b1;
        @(negedge clk); svc_ack = 1'b0;
        chk_svc("R9 pin2 acked, pin0 quiet", 1'b0, 0, 8'h0);

        // R10 masked pending pin 7 shown after unmask
        reg_wr(8'h10 + 8'd14, 32'h0001_0047);
        irq_line[7] = 1'b1;
        @(negedge clk); chk_svc("R10 masked hidden", 1'b0, 0, 8'h0);
        irq_line[7] = 1'b0;
        reg_wr(8'h10 + 8'd14, 32'h0000_0047);
        chk_svc("R10 R11 unmasked shown", 1'b1, 7, 8'h47);

        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule